// File: doc/BRIEF.md
# Dual-Slope PWM Timer with Buffered Compare

This block is a 16-bit counter that counts up from zero to a TOP value and then back down to zero. While it runs, it drives one output pin with a symmetric pulse-width-modulated waveform. The counter does not use a separate clock. It advances on a one-cycle enable pulse from a built-in divider, which divides the system clock by 1, 8, 64, 256 or 1024. The output frequency is f_clk / (2 × N × TOP), where N is the divide ratio.

Software sets the block up through a small write port. The TOP value comes from one of two sources: a dedicated limit register, or the compare register. The limit register, the compare register and the TOP-source select bit are all buffered. Their new values reach the working registers only on the timer tick where the counter sits at zero. This keeps every period symmetric, and it lets TOP change safely while the timer is running.

A compare match drives the output pin in one of four ways: no drive, toggle, clear-on-up, or set-on-up. Two sticky flags record events, one for compare matches and one for reaching zero. Software clears each flag by writing a 1 to its bit.

Top module: `pwm_dual_slope`

## Requirements
- R1: After reset, count_o is 0, pwm_o is 0, both flags are 0, and the divider is stopped.
- R2: ctrl bits [2:0] pick the divide ratio. Code 1 gives /1, 2 gives /8, 3 gives /64, 4 gives /256 and 5 gives /1024. Codes 0, 6 and 7 stop the counter. While running, the count changes once every N clocks.
- R3: With TOP = T > 0, the count runs 0,1,…,T,T-1,…,1,0 and repeats. Each of the two extreme values lasts one tick, so one period is 2T ticks.
- R4: ctrl bit [3] picks the TOP source. A value of 0 uses the limit register (address 1). A value of 1 uses the compare register (address 2).
- R5: Writes to address 1, address 2 and ctrl bit [3] land in buffers. The working values are loaded from these buffers only on a tick where the count is 0, so a running period is never changed.
- R6: ctrl bits [5:4] select the output mode. In mode 2, a match while counting up drives the output low, and a match while counting down drives it high. Mode 3 does the opposite. With compare value C and TOP = T, the output is high for 2C of every 2T ticks in mode 2, and for 2(T−C) ticks in mode 3.
- R7: In mode 2, a compare value of 0 holds the output low and a compare value equal to TOP holds it high. Mode 3 gives the opposite levels.
- R8: Mode 1 toggles the output on each match. With the compare register used as TOP, this gives a 50% duty cycle with a period of 4·TOP ticks.
- R9: Mode 0 holds pwm_o at 0.
- R10: The compare flag is set at the end of a tick in which the count equals the compare value. The bottom flag is set when the count steps from 1 to 0. Both flags stay set until software writes 1 to address 3: bit 0 clears the compare flag and bit 1 clears the bottom flag. If a set and a clear happen in the same cycle, the set wins.
- R11: If the TOP in use is 0, the count holds at 0, the output holds its level, and no flag is set.
- R12: The count never exceeds the working TOP value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 ctrl, 1 limit, 2 compare, 3 flag clear |
| wr_data_i | input | 16 | Write data |
| pwm_o | output | 1 | Waveform output |
| count_o | output | 16 | Current count |
| cmp_flag_o | output | 1 | Sticky compare-match flag |
| bot_flag_o | output | 1 | Sticky bottom-reached flag |

## Verification
The assertions check these properties on every cycle:
- the count stays within the working TOP;
- the count turns around after one tick at each extreme;
- the count holds when TOP is zero;
- the working registers stay frozen between bottom ticks;
- the output level changes only on a match;
- the flags are sticky;
- the divider produces isolated ticks.

Only the bench scenarios can show the following:
- the duty cycles for each mode and compare value;
- the 2T period;
- the divide ratio seen at the count;
- the fact that a TOP written mid-period takes effect one period late.

// File: rtl/pwm_ds_pkg.sv
package pwm_ds_pkg;
  localparam int CNT_W = 16;
  localparam int DIV_W = 10;  // must cover the largest ratio (1024)

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_LIM  = 2'd1;
  localparam logic [1:0] A_CMP  = 2'd2;
  localparam logic [1:0] A_FLAG = 2'd3;

  typedef enum logic [1:0] {
    OM_OFF      = 2'd0,
    OM_TOGGLE   = 2'd1,
    OM_CLEAR_UP = 2'd2,
    OM_SET_UP   = 2'd3
  } out_mode_e;

  // divide ratio for a select code, 0 = stopped
  function automatic int unsigned div_ratio(input logic [2:0] sel);
    case (sel)
      3'd1:    return 1;
      3'd2:    return 1 << 3;
      3'd3:    return 1 << 6;
      3'd4:    return 1 << 8;
      3'd5:    return 1 << 10;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_ds_pkg::*;
#(
  parameter int DW = DIV_W
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  localparam int RW = DW + 1;

  logic [RW-1:0] div_q;
  logic [RW-1:0] ratio;

  always_comb ratio = RW'(div_ratio(sel_i));
  assign tick_o = (ratio != '0) && (div_q >= ratio - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           div_q <= '0;
    else if (ratio == '0)  div_q <= '0;
    else if (tick_o)       div_q <= '0;
    else                   div_q <= div_q + 1'b1;
  end

  // R2: with a ratio above one, ticks never come back to back
  a_r2_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && ratio > 1) |=> (!tick_o || !$stable(sel_i)));
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_ds_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_addr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         upd_i,
  output logic [2:0]   ps_o,
  output out_mode_e    mode_o,
  output logic [W-1:0] top_use_o,
  output logic [W-1:0] cmp_use_o,
  output logic [W-1:0] top_act_o,
  output logic         cmp_clr_o,
  output logic         bot_clr_o
);
  logic [2:0]   ps_q;
  out_mode_e    mode_q;
  logic         tsel_buf_q, tsel_act_q, tsel_n;
  logic [W-1:0] lim_buf_q, lim_act_q, lim_n;
  logic [W-1:0] cmp_buf_q, cmp_act_q, cmp_n;

  always_comb begin
    tsel_n    = upd_i ? tsel_buf_q : tsel_act_q;
    lim_n     = upd_i ? lim_buf_q  : lim_act_q;
    cmp_n     = upd_i ? cmp_buf_q  : cmp_act_q;
    top_use_o = tsel_n ? cmp_n : lim_n;
    cmp_use_o = cmp_n;
    top_act_o = tsel_act_q ? cmp_act_q : lim_act_q;
  end

  assign ps_o      = ps_q;
  assign mode_o    = mode_q;
  assign cmp_clr_o = wr_en_i && (wr_addr_i == A_FLAG) && wr_data_i[0];
  assign bot_clr_o = wr_en_i && (wr_addr_i == A_FLAG) && wr_data_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q       <= '0;
      mode_q     <= OM_OFF;
      tsel_buf_q <= 1'b0;
      tsel_act_q <= 1'b0;
      lim_buf_q  <= '0;
      lim_act_q  <= '0;
      cmp_buf_q  <= '0;
      cmp_act_q  <= '0;
    end else begin
      if (upd_i) begin
        tsel_act_q <= tsel_buf_q;
        lim_act_q  <= lim_buf_q;
        cmp_act_q  <= cmp_buf_q;
      end
      if (wr_en_i) begin
        case (wr_addr_i)
          A_CTRL: begin
            ps_q       <= wr_data_i[2:0];
            tsel_buf_q <= wr_data_i[3];
            mode_q     <= out_mode_e'(wr_data_i[5:4]);
          end
          A_LIM:   lim_buf_q <= wr_data_i;
          A_CMP:   cmp_buf_q <= wr_data_i;
          default: ;
        endcase
      end
    end
  end

  // R5: working values change only on a bottom tick
  a_r5_frozen_between_bottoms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> ($stable(cmp_act_q) && $stable(lim_act_q) && $stable(tsel_act_q)));
endmodule

// File: rtl/pwm_updown_cnt.sv
module pwm_updown_cnt #(
  parameter int W = pwm_ds_pkg::CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] cnt_o,
  output logic         going_up_o,
  output logic         run_o,
  output logic         bottom_o
);
  logic [W-1:0] cnt_q;
  logic         dn_q;

  assign run_o      = (top_i != '0);
  assign going_up_o = (cnt_q == '0) || (!dn_q && cnt_q < top_i);
  assign bottom_o   = tick_i && run_o && !going_up_o && (cnt_q == W'(1));
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else if (tick_i && run_o) begin
      if (going_up_o) begin
        cnt_q <= cnt_q + 1'b1;
        dn_q  <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
        dn_q  <= 1'b1;
      end
    end
  end

  // R3: one tick at TOP, then down
  a_r3_turn_at_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && run_o && cnt_q == top_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R3: one tick at BOTTOM, then up
  a_r3_leave_bottom: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && run_o && cnt_q == '0) |=> (cnt_q == W'(1)));
  // R11: zero TOP holds the count
  a_r11_hold_zero_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !run_o) |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_cmp_out.sv
module pwm_cmp_out
  import pwm_ds_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         run_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cmp_i,
  input  logic         going_up_i,
  input  out_mode_e    mode_i,
  output logic         match_o,
  output logic         pwm_o
);
  logic oc_q;

  assign match_o = tick_i && run_i && (cnt_i == cmp_i);
  assign pwm_o   = (mode_i == OM_OFF) ? 1'b0 : oc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oc_q <= 1'b0;
    else if (match_o) begin
      case (mode_i)
        OM_TOGGLE:   oc_q <= ~oc_q;
        OM_CLEAR_UP: oc_q <= ~going_up_i;
        OM_SET_UP:   oc_q <= going_up_i;
        default:     oc_q <= oc_q;
      endcase
    end
  end

  // R6: the output level moves only on a compare match
  a_r6_level_only_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_o |=> $stable(oc_q));
endmodule

// File: rtl/pwm_dual_slope.sv
module pwm_dual_slope
  import pwm_ds_pkg::*;
#(
  parameter int W  = CNT_W,
  parameter int DW = DIV_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_addr_i,
  input  logic [W-1:0] wr_data_i,
  output logic         pwm_o,
  output logic [W-1:0] count_o,
  output logic         cmp_flag_o,
  output logic         bot_flag_o
);
  logic [2:0]   ps;
  out_mode_e    mode;
  logic         tick, upd, going_up, run, bottom, match;
  logic         cmp_clr, bot_clr;
  logic [W-1:0] top_use, cmp_use, top_act, cnt;
  logic         cf_q, bf_q;

  assign upd = tick && (cnt == '0);

  pwm_prescaler #(.DW(DW)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(ps), .tick_o(tick));

  pwm_regs #(.W(W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .upd_i(upd), .ps_o(ps), .mode_o(mode),
    .top_use_o(top_use), .cmp_use_o(cmp_use), .top_act_o(top_act),
    .cmp_clr_o(cmp_clr), .bot_clr_o(bot_clr));

  pwm_updown_cnt #(.W(W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .top_i(top_use),
    .cnt_o(cnt), .going_up_o(going_up), .run_o(run), .bottom_o(bottom));

  pwm_cmp_out #(.W(W)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .run_i(run), .cnt_i(cnt),
    .cmp_i(cmp_use), .going_up_i(going_up), .mode_i(mode),
    .match_o(match), .pwm_o(pwm_o));

  // sticky flags, a set beats a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cf_q <= 1'b0;
      bf_q <= 1'b0;
    end else begin
      if (match)        cf_q <= 1'b1;
      else if (cmp_clr) cf_q <= 1'b0;
      if (bottom)       bf_q <= 1'b1;
      else if (bot_clr) bf_q <= 1'b0;
    end
  end

  assign count_o    = cnt;
  assign cmp_flag_o = cf_q;
  assign bot_flag_o = bf_q;

  // R12: count stays within the working TOP
  a_r12_within_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= top_act);
  // R10: flags stay set until cleared
  a_r10_cmp_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cf_q && !cmp_clr) |=> cf_q);
  a_r10_bot_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bf_q && !bot_clr) |=> bf_q);
endmodule

// File: tb/sim_pwm_dual_slope.sv
`timescale 1ns/1ps
module sim_pwm_dual_slope;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm;
  logic [15:0] count;
  logic        cf, bf;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_dual_slope u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pwm_o(pwm), .count_o(count),
    .cmp_flag_o(cf), .bot_flag_o(bf));

  // behavioural reference model
  int m_div, m_cnt, m_dn, m_oc, m_cf, m_bf, m_ps, m_mode;
  int m_tsel_b, m_tsel, m_top_b, m_top, m_cmp_b, m_cmp;
  int m_n, m_t, m_up, m_tk;

  function automatic int ratio_of(int s);
    case (s)
      1: return 1;
      2: return 8;
      3: return 64;
      4: return 256;
      5: return 1024;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_cnt = 0; m_dn = 0; m_oc = 0; m_cf = 0; m_bf = 0;
      m_ps = 0; m_mode = 0; m_tsel_b = 0; m_tsel = 0;
      m_top_b = 0; m_top = 0; m_cmp_b = 0; m_cmp = 0;
    end else begin
      m_n = ratio_of(m_ps);
      m_tk = 0;
      if (m_n == 0) m_div = 0;
      else if (m_div >= m_n - 1) begin m_tk = 1; m_div = 0; end
      else m_div++;
      if (wr_en && wr_addr == 2'd3) begin
        if (wr_data[0]) m_cf = 0;
        if (wr_data[1]) m_bf = 0;
      end
      if (m_tk == 1) begin
        if (m_cnt == 0) begin m_top = m_top_b; m_cmp = m_cmp_b; m_tsel = m_tsel_b; end
        m_t = (m_tsel != 0) ? m_cmp : m_top;
        if (m_t != 0) begin
          m_up = (m_cnt == 0 || (m_dn == 0 && m_cnt < m_t)) ? 1 : 0;
          if (m_cnt == m_cmp) begin
            m_cf = 1;
            case (m_mode)
              1: m_oc = 1 - m_oc;
              2: m_oc = 1 - m_up;
              3: m_oc = m_up;
              default: ;
            endcase
          end
          if (m_up == 1) begin m_cnt++; m_dn = 0; end
          else begin if (m_cnt == 1) m_bf = 1; m_cnt--; m_dn = 1; end
        end
      end
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin m_ps = wr_data & 7; m_tsel_b = (wr_data >> 3) & 1; m_mode = (wr_data >> 4) & 3; end
          2'd1: m_top_b = wr_data;
          2'd2: m_cmp_b = wr_data;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model (R3 R6 R10)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(count == 16'(m_cnt), "R3 model count", count, m_cnt);
      chk(pwm == ((m_mode == 0) ? 1'b0 : 1'(m_oc)), "R6 model pwm", pwm, (m_mode == 0) ? 0 : m_oc);
      chk(cf == 1'(m_cf), "R10 model cmp flag", cf, m_cf);
      chk(bf == 1'(m_bf), "R10 model bottom flag", bf, m_bf);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic high_cycles(input int win, output int hi);
    hi = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (pwm) hi++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int hi, mx, last0, gap, spacing;
    logic [15:0] prev;
    logic lvl;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(count == 0 && pwm == 0 && cf == 0 && bf == 0, "R1 reset state", {count, pwm, cf, bf}, 0);
    idle(5);
    chk(count == 0, "R1 stopped after reset", count, 0);

    wr(2'd1, 16'd10);
    wr(2'd2, 16'd4);
    wr(2'd0, 16'h0021);
    idle(45);
    high_cycles(20, hi);
    chk(hi == 8, "R6 mode 2 duty", hi, 8);

    // R3 period and R12 ceiling
    last0 = -1; gap = 0; mx = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (count > mx) mx = count;
      if (count == 0) begin
        if (last0 >= 0) gap = i - last0;
        last0 = i;
      end
    end
    chk(gap == 20, "R3 period 2T", gap, 20);
    chk(mx == 10, "R12 peak equals TOP", mx, 10);

    wr(2'd0, 16'h0031);
    idle(45);
    high_cycles(20, hi);
    chk(hi == 12, "R6 mode 3 duty", hi, 12);

    wr(2'd0, 16'h0021);
    wr(2'd2, 16'd0);
    idle(45);
    high_cycles(20, hi);
    chk(hi == 0, "R7 compare at bottom low", hi, 0);
    wr(2'd2, 16'd10);
    idle(45);
    high_cycles(20, hi);
    chk(hi == 20, "R7 compare at top high", hi, 20);
    wr(2'd0, 16'h0031);
    idle(45);
    high_cycles(20, hi);
    chk(hi == 0, "R7 inverted at top low", hi, 0);
    wr(2'd0, 16'h0021);

    // R5: TOP rewritten mid-period applies from next bottom
    wr(2'd2, 16'd4);
    idle(45);
    prev = count;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (count == 3 && prev == 2) break;
      prev = count;
    end
    wr(2'd1, 16'd6);
    mx = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (count > mx) mx = count;
      if (count == 0) break;
    end
    chk(mx == 10, "R5 running period keeps old TOP", mx, 10);
    mx = 0;
    @(negedge clk);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (count > mx) mx = count;
      if (count == 0) break;
    end
    chk(mx == 6, "R5 new TOP after bottom", mx, 6);

    // R4 R8: compare as TOP with toggle
    wr(2'd2, 16'd8);
    wr(2'd0, 16'h0019);
    idle(60);
    mx = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (count > mx) mx = count;
    end
    chk(mx == 8, "R4 compare register sets TOP", mx, 8);
    high_cycles(32, hi);
    chk(hi == 16, "R8 toggle 50 percent", hi, 16);

    wr(2'd0, 16'h0009);
    high_cycles(32, hi);
    chk(hi == 0, "R9 mode 0 output low", hi, 0);

    // R10 flags
    wr(2'd0, 16'h0000);
    chk(cf == 1 && bf == 1, "R10 flags set by running", {cf, bf}, 3);
    wr(2'd3, 16'h0001);
    chk(cf == 0 && bf == 1, "R10 clear compare flag only", {cf, bf}, 1);
    wr(2'd3, 16'h0002);
    idle(10);
    chk(cf == 0 && bf == 0, "R10 flags stay clear", {cf, bf}, 0);
    wr(2'd0, 16'h0019);
    idle(40);
    chk(cf == 1 && bf == 1, "R10 flags set again", {cf, bf}, 3);

    // R2 divide by 8
    wr(2'd0, 16'h0022);
    idle(20);
    prev = count;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (count != prev) break;
    end
    prev = count; spacing = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      spacing++;
      if (count != prev) break;
    end
    chk(spacing == 8, "R2 divide by 8 spacing", spacing, 8);

    // R11 zero TOP
    wr(2'd1, 16'd0);
    idle(250);
    wr(2'd3, 16'h0003);
    lvl = pwm; mx = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (count != 0 || pwm != lvl || cf || bf) mx++;
    end
    chk(mx == 0, "R11 zero TOP holds everything", mx, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule